// File: doc/BRIEF.md
# Single-Bit Manipulation Execute Unit

This unit is an execute slice for a 64-bit core. It takes an instruction word, a first operand and a second operand, and it carries out one of four single-bit operations on the first operand. It can set one bit, clear one bit, flip one bit, or pull one bit out as a 0 or 1 value. The bit index comes from the low bits of the second operand in register forms. In immediate forms it comes from the shift-amount field of the instruction.

Each operation has a full-width form and a 32-bit word form. The word forms mask the index to five bits. The word forms of set, clear and flip return the low 32 bits sign-extended from bit 31. The word form of extract returns a zero-extended 0 or 1. Any encoding that the unit does not support raises an illegal flag and produces a zero result.

Inputs are taken when `valid_in` is high. The result, the illegal flag and the destination register field appear one clock later with `valid_out`.

Top module: `bitop_unit`

## Requirements
- R1: Opcode 0110011 selects the full-width register forms. With funct3 = 001, funct7 0010100 means set, 0100100 means clear and 0110100 means flip. With funct3 = 101, funct7 0100100 means extract.
- R2: Opcode 0111011 selects the word register forms. They use the same funct3 and funct7 values as R1.
- R3: Opcode 0010011 selects the full-width immediate forms. Bits 31:26 hold the 6-bit function code: 001010 set, 010010 clear, 011010 flip (all with funct3 001), and 010010 extract (with funct3 101). Bits 25:20 hold the index.
- R4: Opcode 0011011 selects the word immediate forms. Bits 31:25 hold the same funct7 values as R1 for set, clear and flip, with funct3 001. Bits 24:20 hold the index. funct3 101 under this opcode is illegal.
- R5: Full-width forms use bits 5:0 of the index source. Word forms use bits 4:0, so a word-form index of 32 acts as index 0. The higher bits of the second operand have no effect.
- R6: The mask is a one shifted left by the index. Set ORs the mask into the first operand, clear ANDs the first operand with the inverted mask, and flip XORs the mask into the first operand.
- R7: Extract returns bit [index] of the first operand in bit 0, with all other bits zero. This holds in both width forms, and the word form is never sign-extended.
- R8: Word set, clear and flip copy bit 31 of the computed value into bits 63:32.
- R9: Any other encoding sets `illegal_out` and gives a result of zero.
- R10: `valid_out` is `valid_in` delayed by one clock. A transfer also registers the result, the illegal flag and the instruction's bits 11:7. These outputs hold their values while `valid_in` is low.
- R11: An active-low synchronous reset clears `valid_out`, `result_out`, `illegal_out` and `rd_out` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_in | input | 1 | Inputs are valid this cycle |
| insn | input | 32 | Instruction word |
| rs1 | input | 64 | First operand, the value that is modified or read |
| rs2 | input | 64 | Second operand, the bit index in register forms |
| valid_out | output | 1 | Registered result is valid |
| rd_out | output | 5 | Destination field, instruction bits 11:7 |
| result_out | output | 64 | Registered result |
| illegal_out | output | 1 | Encoding not supported |

## Verification
The bench builds the unit with its default widths: 64 bits for full forms and 32 bits for word forms. With these widths, indices 32 to 63 behave differently in the two forms. Full forms reach the upper half of the operand, while word forms fold those indices back into the low half. The directed cases use indices 0, 31, 32 and 63 and word results with bit 31 set, so both the masking and the sign-extension boundary are exercised. The random part uses second operands with junk in their upper bits, and also feeds random instruction words to reach the illegal path.

// File: rtl/bitop_pkg.sv
// Shared types and encodings for the single-bit execute unit.
// Assumes a 64-bit datapath, so immediate indices are at most 6 bits wide.
package bitop_pkg;
    typedef enum logic [1:0] {
        BOP_SET = 2'd0,
        BOP_CLR = 2'd1,
        BOP_INV = 2'd2,
        BOP_EXT = 2'd3
    } bop_e;

    typedef struct packed {
        bop_e       op;
        logic       word;
        logic       use_imm;
        logic [5:0] shamt;
        logic       illegal;
    } bop_ctl_t;

    localparam logic [6:0] OPC_REG   = 7'b0110011;
    localparam logic [6:0] OPC_REGW  = 7'b0111011;
    localparam logic [6:0] OPC_IMM   = 7'b0010011;
    localparam logic [6:0] OPC_IMMW  = 7'b0011011;
    localparam logic [6:0] F7_SET    = 7'b0010100;
    localparam logic [6:0] F7_CLR    = 7'b0100100;
    localparam logic [6:0] F7_INV    = 7'b0110100;
    localparam logic [2:0] F3_MOD    = 3'b001;
    localparam logic [2:0] F3_EXT    = 3'b101;
endpackage

// File: rtl/bitop_decode.sv
// Decoder: maps an instruction word to operation, width form, index source
// and shift amount. Assumes only the four major opcodes in bitop_pkg.
module bitop_decode
    import bitop_pkg::*;
(
    input  logic [31:0] insn,
    output bop_ctl_t    ctl
);
    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;
    logic       unused_fields;

    assign opc = insn[6:0];
    assign f3  = insn[14:12];
    assign f7  = insn[31:25];
    assign unused_fields = ^{insn[19:15], insn[11:7]};

    // Classify the opcode, then match the function fields for that form.
    always_comb begin
        ctl         = '0;
        ctl.op      = BOP_SET;
        ctl.illegal = 1'b1;
        unique case (opc)
            OPC_REG, OPC_REGW: begin
                ctl.word = (opc == OPC_REGW);
                if (f3 == F3_MOD) begin
                    ctl.illegal = 1'b0;
                    if (f7 == F7_SET)      ctl.op = BOP_SET;
                    else if (f7 == F7_CLR) ctl.op = BOP_CLR;
                    else if (f7 == F7_INV) ctl.op = BOP_INV;
                    else                   ctl.illegal = 1'b1;
                end else if (f3 == F3_EXT && f7 == F7_CLR) begin
                    ctl.op      = BOP_EXT;
                    ctl.illegal = 1'b0;
                end
            end
            OPC_IMM: begin
                ctl.use_imm = 1'b1;
                ctl.shamt   = insn[25:20];
                if (f3 == F3_MOD) begin
                    ctl.illegal = 1'b0;
                    if (insn[31:26] == F7_SET[6:1])      ctl.op = BOP_SET;
                    else if (insn[31:26] == F7_CLR[6:1]) ctl.op = BOP_CLR;
                    else if (insn[31:26] == F7_INV[6:1]) ctl.op = BOP_INV;
                    else                                 ctl.illegal = 1'b1;
                end else if (f3 == F3_EXT && insn[31:26] == F7_CLR[6:1]) begin
                    ctl.op      = BOP_EXT;
                    ctl.illegal = 1'b0;
                end
            end
            OPC_IMMW: begin
                ctl.use_imm = 1'b1;
                ctl.word    = 1'b1;
                ctl.shamt   = {1'b0, insn[24:20]};
                if (f3 == F3_MOD) begin
                    ctl.illegal = 1'b0;
                    if (f7 == F7_SET)      ctl.op = BOP_SET;
                    else if (f7 == F7_CLR) ctl.op = BOP_CLR;
                    else if (f7 == F7_INV) ctl.op = BOP_INV;
                    else                   ctl.illegal = 1'b1;
                end
            end
            default: ctl.illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/bitop_alu.sv
// Datapath: builds the one-hot mask from the masked index and applies the
// operation. Word forms fold the index to WORD_W and sign-extend the result.
// Assumes XLEN is 64 so the decoded immediate matches the index width.
module bitop_alu
    import bitop_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int WORD_W = 32
) (
    input  bop_ctl_t        ctl,
    input  logic [XLEN-1:0] rs1,
    input  logic [XLEN-1:0] rs2,
    output logic [XLEN-1:0] result
);
    localparam int IDXW  = $clog2(XLEN);
    localparam int WIDXW = $clog2(WORD_W);

    logic [IDXW-1:0] idx_src;
    logic [IDXW-1:0] idx;
    logic [XLEN-1:0] mask;
    logic [XLEN-1:0] raw;
    logic            unused_rs2;

    assign unused_rs2 = ^rs2[XLEN-1:IDXW];

    // Choose the index source and fold it to the active width.
    always_comb begin
        idx_src = ctl.use_imm ? ctl.shamt[IDXW-1:0] : rs2[IDXW-1:0];
        idx     = ctl.word ? {{(IDXW-WIDXW){1'b0}}, idx_src[WIDXW-1:0]} : idx_src;
        mask    = {{(XLEN-1){1'b0}}, 1'b1} << idx;
    end

    // Apply the operation, then the width and legality adjustments.
    always_comb begin
        unique case (ctl.op)
            BOP_SET: raw = rs1 | mask;
            BOP_CLR: raw = rs1 & ~mask;
            BOP_INV: raw = rs1 ^ mask;
            default: raw = {{(XLEN-1){1'b0}}, rs1[idx]};
        endcase
        if (ctl.illegal)
            result = '0;
        else if (ctl.word && ctl.op != BOP_EXT)
            result = {{(XLEN-WORD_W){raw[WORD_W-1]}}, raw[WORD_W-1:0]};
        else
            result = raw;
    end

    // R7
    always_comb begin
        ext_upper_zero_chk: assert (ctl.illegal || ctl.op != BOP_EXT || result[XLEN-1:1] == '0);
    end
endmodule

// File: rtl/bitop_unit.sv
// Top: decoder plus datapath, with one register stage at the output.
// Inputs are taken on a clock edge where valid_in is high; the outputs hold
// otherwise. Reset is synchronous and active low.
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int WORD_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_in,
    input  logic [31:0]     insn,
    input  logic [XLEN-1:0] rs1,
    input  logic [XLEN-1:0] rs2,
    output logic            valid_out,
    output logic [4:0]      rd_out,
    output logic [XLEN-1:0] result_out,
    output logic            illegal_out
);
    bop_ctl_t        ctl;
    logic [XLEN-1:0] result_c;

    bitop_decode u_dec (
        .insn (insn),
        .ctl  (ctl)
    );

    bitop_alu #(.XLEN(XLEN), .WORD_W(WORD_W)) u_alu (
        .ctl    (ctl),
        .rs1    (rs1),
        .rs2    (rs2),
        .result (result_c)
    );

    // Output register stage: load on valid_in, track valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_out   <= 1'b0;
            rd_out      <= '0;
            result_out  <= '0;
            illegal_out <= 1'b0;
        end else begin
            valid_out <= valid_in;
            if (valid_in) begin
                rd_out      <= insn[11:7];
                result_out  <= result_c;
                illegal_out <= ctl.illegal;
            end
        end
    end

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);
    // R10
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out);
    // R10
    rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> rd_out == $past(insn[11:7]));
    // R9
    illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in && ctl.illegal |=> illegal_out && result_out == '0);
    // R8
    word_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in && !ctl.illegal && ctl.word && ctl.op != BOP_EXT
        |=> result_out[XLEN-1:WORD_W] == {(XLEN-WORD_W){result_out[WORD_W-1]}});
    // R6
    single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in && !ctl.illegal && !ctl.word && ctl.op != BOP_EXT
        |=> $countones(result_out ^ $past(rs1)) <= 1);
    // R7
    ext_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in && !ctl.illegal && ctl.op == BOP_EXT |=> result_out[XLEN-1:1] == '0);
endmodule

// File: tb/bitop_unit_test.sv
`timescale 1ns/1ps
module bitop_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [31:0] insn = '0;
    logic [63:0] rs1 = '0;
    logic [63:0] rs2 = '0;
    logic        valid_out;
    logic [4:0]  rd_out;
    logic [63:0] result_out;
    logic        illegal_out;
    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    bitop_unit uut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .insn(insn),
        .rs1(rs1), .rs2(rs2), .valid_out(valid_out), .rd_out(rd_out),
        .result_out(result_out), .illegal_out(illegal_out)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural model: returns {illegal, result}.
    function automatic logic [64:0] model(logic [31:0] w, logic [63:0] a, logic [63:0] b);
        int kind = -1;
        bit wide_form = 1'b1;
        bit imm = 1'b0;
        int pos;
        logic [63:0] r;
        logic [63:0] bitv;
        case (w[6:0])
            7'b0110011, 7'b0111011: begin
                wide_form = (w[6:0] == 7'b0110011);
                if (w[14:12] == 3'b001 && w[31:25] == 7'b0010100) kind = 0;
                if (w[14:12] == 3'b001 && w[31:25] == 7'b0100100) kind = 1;
                if (w[14:12] == 3'b001 && w[31:25] == 7'b0110100) kind = 2;
                if (w[14:12] == 3'b101 && w[31:25] == 7'b0100100) kind = 3;
            end
            7'b0010011: begin
                imm = 1'b1;
                if (w[14:12] == 3'b001 && w[31:26] == 6'b001010) kind = 0;
                if (w[14:12] == 3'b001 && w[31:26] == 6'b010010) kind = 1;
                if (w[14:12] == 3'b001 && w[31:26] == 6'b011010) kind = 2;
                if (w[14:12] == 3'b101 && w[31:26] == 6'b010010) kind = 3;
            end
            7'b0011011: begin
                imm = 1'b1;
                wide_form = 1'b0;
                if (w[14:12] == 3'b001 && w[31:25] == 7'b0010100) kind = 0;
                if (w[14:12] == 3'b001 && w[31:25] == 7'b0100100) kind = 1;
                if (w[14:12] == 3'b001 && w[31:25] == 7'b0110100) kind = 2;
            end
            default: kind = -1;
        endcase
        if (kind < 0) return {1'b1, 64'd0};
        if (imm) pos = wide_form ? int'(w[25:20]) : int'(w[24:20]);
        else     pos = wide_form ? int'(b[5:0]) : int'(b[4:0]);
        bitv = 64'd1 << pos;
        case (kind)
            0: r = a | bitv;
            1: r = a & ~bitv;
            2: r = a ^ bitv;
            default: r = {63'd0, a[pos]};
        endcase
        if (!wide_form && kind != 3) r = {{32{r[31]}}, r[31:0]};
        return {1'b0, r};
    endfunction

    function automatic logic [31:0] enc_r(logic [6:0] f7, logic [2:0] f3, logic [6:0] opc);
        return {f7, 5'($urandom), 5'($urandom), f3, 5'($urandom), opc};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] f6, logic [5:0] sh, logic [2:0] f3);
        return {f6, sh, 5'($urandom), f3, 5'($urandom), 7'b0010011};
    endfunction

    function automatic logic [31:0] enc_iw(logic [6:0] f7, logic [4:0] sh, logic [2:0] f3);
        return {f7, sh, 5'($urandom), f3, 5'($urandom), 7'b0011011};
    endfunction

    task automatic run_op(input logic [31:0] w, input logic [63:0] a,
                          input logic [63:0] b, input string tag);
        logic [64:0] e;
        e = model(w, a, b);
        @(negedge clk);
        insn = w; rs1 = a; rs2 = b; valid_in = 1'b1;
        @(negedge clk);
        valid_in = 1'b0;
        check(valid_out == 1'b1, {tag, " R10 valid"}, 64'(valid_out), 64'd1);
        check(result_out == e[63:0], {tag, " result"}, result_out, e[63:0]);
        check(illegal_out == e[64], {tag, " illegal"}, 64'(illegal_out), 64'(e[64]));
        check(rd_out == w[11:7], {tag, " R10 rd"}, 64'(rd_out), 64'(w[11:7]));
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [6:0] f7s [3];
        logic [5:0] idxs [4];
        logic [63:0] held;
        void'($urandom(32'd20201));
        f7s[0] = 7'b0010100; f7s[1] = 7'b0100100; f7s[2] = 7'b0110100;
        idxs[0] = 6'd0; idxs[1] = 6'd31; idxs[2] = 6'd32; idxs[3] = 6'd63;

        insn = 32'h0123_4567; rs1 = '1; rs2 = '1;
        valid_in = 1'b1;
        repeat (3) @(negedge clk);
        valid_in = 1'b0;
        // R11: reset state after valid_in was high during reset
        check(valid_out == 1'b0, "R11 valid_out", 64'(valid_out), 64'd0);
        check(result_out == '0, "R11 result_out", result_out, 64'd0);
        check(illegal_out == 1'b0 && rd_out == '0, "R11 flags", 64'({illegal_out, rd_out}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed boundary indices on every form
        foreach (idxs[k]) begin
            for (int op = 0; op < 3; op++) begin
                run_op(enc_r(f7s[op], 3'b001, 7'b0110011), 64'hA5A5_5A5A_F00F_0FF0,
                       {58'h2AB_CDEF_1234_567, idxs[k]}, "R1 R5 R6");
                run_op(enc_r(f7s[op], 3'b001, 7'b0111011), 64'h1234_5678_0F0F_7F0F,
                       {58'h3FF_FFFF_FFFF_FFF, idxs[k]}, "R2 R5 R8");
                run_op(enc_i({f7s[op][6:1]}, idxs[k], 3'b001), 64'hFFFF_0000_8000_0001, 64'd0, "R3 R6");
                run_op(enc_iw(f7s[op], idxs[k][4:0], 3'b001), 64'h0000_0000_7FFF_FFFF, 64'd0, "R4 R8");
            end
            run_op(enc_r(7'b0100100, 3'b101, 7'b0110011), 64'h8000_0001_8000_0001, {58'h1, idxs[k]}, "R1 R7");
            run_op(enc_r(7'b0100100, 3'b101, 7'b0111011), 64'h8000_0001_8000_0001, {58'h1, idxs[k]}, "R2 R7");
            run_op(enc_i(6'b010010, idxs[k], 3'b101), 64'h8000_0001_8000_0001, 64'd0, "R3 R7");
        end

        // Word set at bit 31 gives negative result; word extract of bit 31 stays 1
        run_op(enc_iw(7'b0010100, 5'd31, 3'b001), 64'd0, 64'd0, "R8 sext");
        run_op(enc_r(7'b0100100, 3'b101, 7'b0111011), 64'h0000_0000_8000_0000, 64'd31, "R7 word ext");
        // Word immediate extract is illegal
        run_op(enc_iw(7'b0100100, 5'd3, 3'b101), 64'hFFFF, 64'd0, "R4 R9");
        // Nearby but unsupported encodings
        run_op(enc_r(7'b0000000, 3'b001, 7'b0110011), 64'hFF, 64'd1, "R9 f7");
        run_op(enc_r(7'b0010100, 3'b101, 7'b0110011), 64'hFF, 64'd1, "R9 f3");
        run_op(enc_i(6'b000000, 6'd5, 3'b001), 64'hFF, 64'd1, "R9 imm");

        // R10: outputs hold while valid_in is low
        held = result_out;
        @(negedge clk);
        insn = enc_r(7'b0010100, 3'b001, 7'b0110011); rs1 = '0; rs2 = 64'd9;
        @(negedge clk);
        check(valid_out == 1'b0, "R10 idle valid", 64'(valid_out), 64'd0);
        check(result_out == held, "R10 hold", result_out, held);

        // Random mix
        for (int i = 0; i < 800; i++) begin
            int cls = $urandom_range(0, 4);
            int op = $urandom_range(0, 3);
            logic [63:0] a = {$urandom, $urandom};
            logic [63:0] b = {$urandom, $urandom};
            logic [5:0] sh = 6'($urandom);
            logic [2:0] f3 = (op == 3) ? 3'b101 : 3'b001;
            logic [6:0] f7 = (op == 3) ? 7'b0100100 : f7s[op];
            if ($urandom_range(0, 3) == 0) begin
                sh = idxs[$urandom_range(0, 3)];
                b[5:0] = sh;
            end
            case (cls)
                0: run_op(enc_r(f7, f3, 7'b0110011), a, b, "R1 rnd");
                1: run_op(enc_r(f7, f3, 7'b0111011), a, b, "R2 rnd");
                2: run_op(enc_i(f7[6:1], sh, f3), a, b, "R3 rnd");
                3: run_op(enc_iw(f7, sh[4:0], f3), a, b, "R4 rnd");
                default: run_op($urandom, a, b, "R9 rnd");
            endcase
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule